// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block collects a bank of level-sensitive interrupt lines from peripherals and reduces them to one request for an upstream primary interrupt controller. Each line is captured into a level register. Software can raise extra lines of its own, and these are ORed into the captured levels to form the effective level. An enable mask then selects which effective lines contribute to the single merged request.

A fixed window of lines (bits 21 to 30 at the default size) can also be routed to dedicated upstream request outputs, one output per line. Routing is switched on and off per line. A routed output follows the effective level of its line and does not depend on the enable mask, so the primary controller can see those sources as separate inputs. All control goes through a small register port with a byte address, a write strobe, write data and combinational read data. Registers are decoded by word index, which is the address shifted right by two.

The block has no sequencing of its own and therefore no state machine. It has three parts. The level stage is a single register stage. The register file holds the write-side state: the mask, software and routing registers. The router is purely combinational.

Top module: `irqx_top`

## Requirements
- R1: Each interrupt input is captured into a level register on every rising clock edge. Reading word index 1 returns the effective level, which is the captured level ORed with the software register.
- R2: `irq_out` is high exactly when (effective level AND enable mask) is nonzero. Reading word index 0 returns that same AND.
- R3: Writing word index 2 sets the mask bits written as ones. Writing word index 3 clears the mask bits written as ones. Reading word index 2 returns the mask.
- R4: Writing word index 4 sets the software bits written as ones. Writing word index 5 clears them. Reading index 4 returns the software register, whose bits act exactly like asserted inputs.
- R5: Writing word index 8 sets routing enable bits, but only inside the window 0x7FE00000 (bits 21 to 30). All other routing bits stay zero. Reading index 8 returns the routing enables.
- R6: Writing word index 9 clears the routing enable bits written as ones.
- R7: `route_out[k]` equals effective level bit 21+k while routing bit 21+k is set, and is low while that bit is clear. It reflects any change of input or enable from the next clock edge.
- R8: Routed outputs ignore the enable mask. A routed line with its mask bit clear still drives its output.
- R9: Unmapped word indices, and any address whose two low bits are nonzero, read as zero and leave all registers unchanged when written.
- R10: Asynchronous active-low reset clears the level, mask, software and routing registers, which drives `irq_out` and every `route_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| irq_out | output | 1 | Merged masked request |
| route_out | output | 10 | Direct per-line requests for the routing window |

## Verification
The bench builds the block with its default parameters: 32 lines, a 10-line routing window starting at bit 21, and a 6-bit address. This puts both window edges within reach: bit 21 and bit 30 are driven through the routing path, and writes of all ones show that bits 20 and 31 can never be enabled. The 6-bit address also reaches unmapped indices and misaligned addresses, so the ignored-write cases can be checked through readback.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    typedef enum logic [3:0] {
        IDX_STATUS   = 4'd0,
        IDX_LEVEL    = 4'd1,
        IDX_MASK_SET = 4'd2,
        IDX_MASK_CLR = 4'd3,
        IDX_SOFT_SET = 4'd4,
        IDX_SOFT_CLR = 4'd5,
        IDX_ROUT_SET = 4'd8,
        IDX_ROUT_CLR = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/irqx_level.sv
module irqx_level #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic [N_LINES-1:0] soft_q,
    output logic [N_LINES-1:0] eff_level
);

    logic [N_LINES-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= irq_in;
        end
    end

    always_comb begin
        eff_level = level_q | soft_q;
    end

    // R1: a line driven high is seen in the effective level one edge later
    p_level_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((eff_level & $past(irq_in)) == $past(irq_in)));

endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int ROUT_LO = 21,
    parameter int ROUT_N  = 10,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wdata,
    input  logic [N_LINES-1:0] eff_level,
    output logic [N_LINES-1:0] mask_q,
    output logic [N_LINES-1:0] soft_q,
    output logic [N_LINES-1:0] rout_en_q,
    output logic [N_LINES-1:0] rdata
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [N_LINES-1:0] ALL_ONES = '1;
    localparam logic [N_LINES-1:0] ROUT_WIN = (ALL_ONES >> (N_LINES - ROUT_N)) << ROUT_LO;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             do_wr;

    always_comb begin
        idx     = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        do_wr   = wr_en && aligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            soft_q    <= '0;
            rout_en_q <= '0;
        end else if (do_wr) begin
            case (idx)
                IDX_W'(IDX_MASK_SET): mask_q    <= mask_q | wdata;
                IDX_W'(IDX_MASK_CLR): mask_q    <= mask_q & ~wdata;
                IDX_W'(IDX_SOFT_SET): soft_q    <= soft_q | wdata;
                IDX_W'(IDX_SOFT_CLR): soft_q    <= soft_q & ~wdata;
                IDX_W'(IDX_ROUT_SET): rout_en_q <= rout_en_q | (wdata & ROUT_WIN);
                IDX_W'(IDX_ROUT_CLR): rout_en_q <= rout_en_q & ~wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(IDX_STATUS):   rdata = eff_level & mask_q;
                IDX_W'(IDX_LEVEL):    rdata = eff_level;
                IDX_W'(IDX_MASK_SET): rdata = mask_q;
                IDX_W'(IDX_SOFT_SET): rdata = soft_q;
                IDX_W'(IDX_ROUT_SET): rdata = rout_en_q;
                default:              rdata = '0;
            endcase
        end
    end

    // R4: bits written to the software set index are present afterwards
    p_soft_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_W'(IDX_SOFT_SET)) |=> ((soft_q & $past(wdata)) == $past(wdata)));

    // R3: bits written to the mask clear index are gone afterwards
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_W'(IDX_MASK_CLR)) |=> ((mask_q & $past(wdata)) == '0));

    // R9: a misaligned or unmapped write leaves every register unchanged
    p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!aligned || idx == IDX_W'(IDX_STATUS) || idx == IDX_W'(IDX_LEVEL)
                   || idx > IDX_W'(IDX_ROUT_CLR) || idx == IDX_W'(6) || idx == IDX_W'(7)))
        |=> ($stable(mask_q) && $stable(soft_q) && $stable(rout_en_q)));

    // R5: a routing set write never reaches bits outside the window
    p_rout_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_W'(IDX_ROUT_SET)) |=> ((rout_en_q & ~ROUT_WIN) == '0));

endmodule

// File: rtl/irqx_route.sv
module irqx_route #(
    parameter int N_LINES = 32,
    parameter int ROUT_LO = 21,
    parameter int ROUT_N  = 10
) (
    input  logic [N_LINES-1:0] eff_level,
    input  logic [N_LINES-1:0] mask_q,
    input  logic [ROUT_N-1:0]  rout_en,
    output logic               irq_out,
    output logic [ROUT_N-1:0]  route_out
);

    always_comb begin
        irq_out = |(eff_level & mask_q);
    end

    for (genvar k = 0; k < ROUT_N; k++) begin : g_lane
        always_comb begin
            route_out[k] = rout_en[k] & eff_level[ROUT_LO + k];
        end
    end

endmodule

// File: rtl/irqx_top.sv
module irqx_top #(
    parameter int N_LINES = 32,
    parameter int ROUT_LO = 21,
    parameter int ROUT_N  = 10,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               irq_out,
    output logic [ROUT_N-1:0]  route_out
);

    logic [N_LINES-1:0] eff_level;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] soft_q;
    logic [N_LINES-1:0] rout_en_q;

    irqx_level #(.N_LINES(N_LINES)) i_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .soft_q    (soft_q),
        .eff_level (eff_level)
    );

    irqx_regs #(
        .N_LINES (N_LINES),
        .ROUT_LO (ROUT_LO),
        .ROUT_N  (ROUT_N),
        .ADDR_W  (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .eff_level (eff_level),
        .mask_q    (mask_q),
        .soft_q    (soft_q),
        .rout_en_q (rout_en_q),
        .rdata     (rdata)
    );

    irqx_route #(
        .N_LINES (N_LINES),
        .ROUT_LO (ROUT_LO),
        .ROUT_N  (ROUT_N)
    ) i_route (
        .eff_level (eff_level),
        .mask_q    (mask_q),
        .rout_en   (rout_en_q[ROUT_LO +: ROUT_N]),
        .irq_out   (irq_out),
        .route_out (route_out)
    );

    // R2: with an all-zero mask the merged request stays low
    p_quiet_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

    // R2: the status readback never shows a bit the mask does not allow
    p_status_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> ((rdata & ~mask_q) == '0));

    for (genvar k = 0; k < ROUT_N; k++) begin : g_chk
        // R7: a lane with routing disabled is held low
        p_lane_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !rout_en_q[ROUT_LO + k] |-> !route_out[k]);
        // R8: an enabled lane is high when its input was high, whatever the mask
        p_lane_skips_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rout_en_q[ROUT_LO + k] && $past(irq_in[ROUT_LO + k])) |-> route_out[k]);
    end

endmodule

// File: tb/test_irqx_top.sv
module test_irqx_top;

    localparam int NV = 34;
    // entry: {req[3:0], op[1:0], addr[5:0], data[31:0], exp[31:0]}
    // op 0 write, 1 read and compare rdata, 2 drive irq_in, 3 compare {irq_out, route_out}
    localparam logic [75:0] VEC [NV] = '{
        {4'd1,  2'd2, 6'h00, 32'h0000_0009, 32'h0},           // R1 drive
        {4'd1,  2'd1, 6'h04, 32'h0,         32'h0000_0009},   // R1
        {4'd2,  2'd3, 6'h00, 32'h0,         32'h0},           // R2 no mask
        {4'd3,  2'd0, 6'h08, 32'h0000_0001, 32'h0},           // R3 set mask
        {4'd3,  2'd1, 6'h08, 32'h0,         32'h0000_0001},   // R3
        {4'd2,  2'd3, 6'h00, 32'h0,         32'h0000_0400},   // R2
        {4'd2,  2'd1, 6'h00, 32'h0,         32'h0000_0001},   // R2 status
        {4'd3,  2'd0, 6'h0C, 32'h0000_0001, 32'h0},           // R3 clear
        {4'd3,  2'd1, 6'h08, 32'h0,         32'h0},           // R3
        {4'd2,  2'd3, 6'h00, 32'h0,         32'h0},           // R2
        {4'd4,  2'd0, 6'h10, 32'h0000_0100, 32'h0},           // R4 soft set
        {4'd4,  2'd1, 6'h10, 32'h0,         32'h0000_0100},   // R4
        {4'd4,  2'd1, 6'h04, 32'h0,         32'h0000_0109},   // R4 in level
        {4'd3,  2'd0, 6'h08, 32'h0000_0100, 32'h0},           // R3 mask bit8
        {4'd4,  2'd3, 6'h00, 32'h0,         32'h0000_0400},   // R4 soft drives out
        {4'd4,  2'd0, 6'h14, 32'h0000_0100, 32'h0},           // R4 soft clear
        {4'd4,  2'd3, 6'h00, 32'h0,         32'h0},           // R4
        {4'd4,  2'd1, 6'h10, 32'h0,         32'h0},           // R4
        {4'd5,  2'd0, 6'h20, 32'hFFFF_FFFF, 32'h0},           // R5 set all
        {4'd5,  2'd1, 6'h20, 32'h0,         32'h7FE0_0000},   // R5 window only
        {4'd7,  2'd3, 6'h00, 32'h0,         32'h0},           // R7 no input
        {4'd7,  2'd2, 6'h00, 32'h0020_0009, 32'h0},           // R7 bit21
        {4'd8,  2'd3, 6'h00, 32'h0,         32'h0000_0001},   // R8 lane0 unmasked
        {4'd6,  2'd0, 6'h24, 32'h0020_0000, 32'h0},           // R6 clear bit21
        {4'd6,  2'd1, 6'h20, 32'h0,         32'h7FC0_0000},   // R6
        {4'd7,  2'd3, 6'h00, 32'h0,         32'h0},           // R7 disabled low
        {4'd9,  2'd0, 6'h30, 32'hFFFF_FFFF, 32'h0},           // R9 unmapped write
        {4'd9,  2'd1, 6'h30, 32'h0,         32'h0},           // R9 reads zero
        {4'd9,  2'd0, 6'h09, 32'hFFFF_FFFF, 32'h0},           // R9 misaligned write
        {4'd9,  2'd1, 6'h08, 32'h0,         32'h0000_0100},   // R9 mask unchanged
        {4'd9,  2'd1, 6'h20, 32'h0,         32'h7FC0_0000},   // R9 routing unchanged
        {4'd7,  2'd2, 6'h00, 32'h4000_0100, 32'h0},           // R7 bit30 and bit8
        {4'd7,  2'd3, 6'h00, 32'h0,         32'h0000_0600},   // R7 lane9 plus merged
        {4'd9,  2'd1, 6'h06, 32'h0,         32'h0}            // R9 misaligned read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;
    logic [9:0]  route_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqx_top i_irqx_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out), .route_out(route_out)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic out_check(input int req, input logic [31:0] exp);
        @(negedge clk); #1;
        check(req, {21'd0, irq_out, route_out}, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state visible at the ports while held in reset
        @(negedge clk); #1;
        check(10, {21'd0, irq_out, route_out}, 32'h0);
        rst_n = 1'b1;
        rd_check(10, 6'h08, 32'h0);  // R10 mask
        rd_check(10, 6'h10, 32'h0);  // R10 soft
        rd_check(10, 6'h20, 32'h0);  // R10 routing

        for (int i = 0; i < NV; i++) begin
            logic [75:0] v;
            v = VEC[i];
            case (v[71:70])
                2'd0: wr(v[69:64], v[63:32]);
                2'd1: rd_check(int'(v[75:72]), v[69:64], v[31:0]);
                2'd2: begin
                    @(negedge clk);
                    irq_in = v[63:32];
                    @(posedge clk); #1;
                end
                default: out_check(int'(v[75:72]), v[31:0]);
            endcase
        end

        // R10: reset in mid-run clears every register and output
        wr(6'h10, 32'h4000_0000);
        out_check(10, 32'h0000_0600);
        @(negedge clk);
        rst_n = 1'b0;
        irq_in = '0;
        #1;
        check(10, {21'd0, irq_out, route_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_check(10, 6'h04, 32'h0);
        rd_check(10, 6'h08, 32'h0);
        rd_check(10, 6'h20, 32'h0);

        // R5: bit 20 and bit 31 never become routing enables
        wr(6'h20, 32'h8010_0000);
        rd_check(5, 6'h20, 32'h0);

        // R7: an enable change alone refreshes the lane from the live level
        @(negedge clk);
        irq_in = 32'h0020_0000;
        @(posedge clk); #1;
        out_check(7, 32'h0);
        wr(6'h20, 32'h0020_0000);
        out_check(7, 32'h0000_0001);

        finish_run();
    end

endmodule